// File: doc/BRIEF.md
# Nonvolatile Store/Recall Cycle Sequencer

This block runs the internal timing of the two bulk transfers between an SRAM array and its nonvolatile shadow. A store runs two ordered phases: the old nonvolatile contents are erased, then the new contents are programmed. A recall also runs two ordered phases: the SRAM is cleared, then the nonvolatile image is copied into it. Each phase drives a strobe for the memory array. The length of each phase is a separate parameter, counted in clock cycles.

Requests reach the block from two sources. A command decoder sends single-cycle store and recall pulses. A supply monitor sends a level flag that is high while the supply is above its switching threshold. Reset, and any cycle with the flag low, latch a pending recall. That recall starts by itself once the supply is good again, and it takes priority over software commands. Only one operation runs at a time. For the whole of an operation, SRAM access is inhibited. The active-low busy output is held low for the whole of a store and the whole of a supply-triggered recall.

Top module: `nvs_seq`

## Requirements
- R1: The cycle after a store pulse is accepted, `erase_en` is high for exactly ERASE_CYC cycles. `prog_en` is then high for exactly PROG_CYC cycles, and after that the block is idle.
- R2: The cycle after a software recall pulse is accepted, `clear_en` is high for exactly CLEAR_CYC cycles. `xfer_en` is then high for exactly XFER_CYC cycles. `busy_n` stays high throughout a software recall.
- R3: `access_block` is high in every cycle in which any phase strobe is high. It is low when the block is idle, the supply flag is high and no recall is pending.
- R4: `busy_n` is low in every cycle of a store and every cycle of a supply-triggered recall.
- R5: While reset is asserted, a recall is latched and `access_block` is high. In the first cycle after reset is released with the supply flag high, the latched recall starts (clear, then transfer) with `busy_n` low.
- R6: A low supply flag sampled at a clock edge ends any running phase at that edge and latches a recall. While the flag stays low, `access_block` stays high. The first edge that samples the flag high again starts the latched recall.
- R7: Store or recall pulses that arrive while an operation runs are dropped and not queued. The block returns to idle when the running operation ends.
- R8: A pending latched recall wins over a store pulse that arrives in the same cycle. The store pulse is dropped.
- R9: When store and recall pulses arrive in the same idle cycle, the store runs and the recall is dropped.
- R10: At most one of the four phase strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | High while the supply is above the switching threshold |
| store_req | input | 1 | One-cycle store command pulse |
| recall_req | input | 1 | One-cycle software recall command pulse |
| erase_en | output | 1 | Nonvolatile erase phase strobe |
| prog_en | output | 1 | Nonvolatile program phase strobe |
| clear_en | output | 1 | SRAM clear phase strobe |
| xfer_en | output | 1 | Nonvolatile-to-SRAM transfer phase strobe |
| access_block | output | 1 | High while SRAM reads and writes are inhibited |
| busy_n | output | 1 | Active-low busy for a store or a supply-triggered recall |

## Verification
The bound assertions check the following on every cycle:
- at most one phase strobe is high;
- erase hands over to program, and clear hands over to transfer, unless the supply dropped;
- an erase phase never runs longer than its parameter allows;
- any active phase inhibits access, and busy is low during a store;
- a supply drop stops all phases by the next edge;
- each accepted start produces its first phase at the next edge.

Some behaviours need a whole scenario, so only the bench can show them:
- exact phase lengths;
- commands dropped rather than queued;
- the power-up recall after reset;
- the priority between a pending recall and a store;
- the priority between a store and a recall.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ERASE = 3'd1,
    PH_PROG  = 3'd2,
    PH_CLEAR = 3'd3,
    PH_XFER  = 3'd4
  } nvs_phase_e;

  // Largest of four phase lengths
  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Counter width able to hold the largest reload value (length - 1)
  function automatic int unsigned ctr_width(input int unsigned longest);
    return (longest < 2) ? 1 : $clog2(longest);
  endfunction

  // Reload value loaded when a phase is entered: phase lasts len cycles
  function automatic int unsigned phase_reload(input nvs_phase_e ph,
                                               input int unsigned e_len, input int unsigned p_len,
                                               input int unsigned c_len, input int unsigned x_len);
    case (ph)
      PH_ERASE: return e_len - 1;
      PH_PROG:  return p_len - 1;
      PH_CLEAR: return c_len - 1;
      PH_XFER:  return x_len - 1;
      default:  return 0;
    endcase
  endfunction

  // Total cycle count of an operation built from two phases
  function automatic int unsigned op_cycles(input int unsigned first, input int unsigned second);
    return first + second;
  endfunction

endpackage

// File: rtl/nvs_pend_latch.sv
module nvs_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic take,
  output logic pend
);

  // Reset stands for power-up: a recall is owed from the start.
  // A low supply sets the latch and wins over take.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend <= 1'b1;
    else if (!supply_ok) pend <= 1'b1;
    else if (take)       pend <= 1'b0;
  end

endmodule

// File: rtl/nvs_phase_ctr.sv
module nvs_phase_ctr #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/nvs_seq_fsm.sv
module nvs_seq_fsm
  import nvs_pkg::*;
#(
  parameter int unsigned ERASE_CYC = 5,
  parameter int unsigned PROG_CYC  = 7,
  parameter int unsigned CLEAR_CYC = 3,
  parameter int unsigned XFER_CYC  = 4,
  parameter int unsigned W         = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok,
  input  logic         pend,
  input  logic         store_req,
  input  logic         recall_req,
  input  logic         ctr_done,
  output nvs_phase_e   phase,
  output logic         hw_op,
  output logic         ctr_load,
  output logic [W-1:0] ctr_val,
  output logic         take_hw,
  output logic         start_store,
  output logic         start_swrec
);

  nvs_phase_e phase_d;
  logic       hw_d;

  always_comb begin
    phase_d     = phase;
    hw_d        = hw_op;
    take_hw     = 1'b0;
    start_store = 1'b0;
    start_swrec = 1'b0;
    if (!supply_ok) begin
      phase_d = PH_IDLE;
      hw_d    = 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (pend) begin
            take_hw = 1'b1;
            phase_d = PH_CLEAR;
            hw_d    = 1'b1;
          end else if (store_req) begin
            start_store = 1'b1;
            phase_d     = PH_ERASE;
            hw_d        = 1'b0;
          end else if (recall_req) begin
            start_swrec = 1'b1;
            phase_d     = PH_CLEAR;
            hw_d        = 1'b0;
          end
        end
        PH_ERASE: if (ctr_done) phase_d = PH_PROG;
        PH_PROG:  if (ctr_done) phase_d = PH_IDLE;
        PH_CLEAR: if (ctr_done) phase_d = PH_XFER;
        PH_XFER:  if (ctr_done) phase_d = PH_IDLE;
        default:  phase_d = PH_IDLE;
      endcase
    end
  end

  assign ctr_load = (phase_d != phase) && (phase_d != PH_IDLE);
  assign ctr_val  = W'(phase_reload(phase_d, ERASE_CYC, PROG_CYC, CLEAR_CYC, XFER_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      hw_op <= 1'b0;
    end else begin
      phase <= phase_d;
      hw_op <= hw_d;
    end
  end

endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int unsigned ERASE_CYC = 5,
  parameter int unsigned PROG_CYC  = 7,
  parameter int unsigned CLEAR_CYC = 3,
  parameter int unsigned XFER_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic store_req,
  input  logic recall_req,
  output logic erase_en,
  output logic prog_en,
  output logic clear_en,
  output logic xfer_en,
  output logic access_block,
  output logic busy_n
);

  localparam int unsigned LONGEST = max4(ERASE_CYC, PROG_CYC, CLEAR_CYC, XFER_CYC);
  localparam int unsigned W       = ctr_width(LONGEST);

  nvs_phase_e   phase;
  logic         hw_op;
  logic         pend;
  logic         take_hw;
  logic         start_store;
  logic         start_swrec;
  logic         ctr_load;
  logic [W-1:0] ctr_val;
  logic         ctr_done;
  logic         op_running;

  nvs_pend_latch u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .take      (take_hw),
    .pend      (pend)
  );

  nvs_phase_ctr #(.W(W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val (ctr_val),
    .done     (ctr_done)
  );

  nvs_seq_fsm #(
    .ERASE_CYC (ERASE_CYC),
    .PROG_CYC  (PROG_CYC),
    .CLEAR_CYC (CLEAR_CYC),
    .XFER_CYC  (XFER_CYC),
    .W         (W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .pend        (pend),
    .store_req   (store_req),
    .recall_req  (recall_req),
    .ctr_done    (ctr_done),
    .phase       (phase),
    .hw_op       (hw_op),
    .ctr_load    (ctr_load),
    .ctr_val     (ctr_val),
    .take_hw     (take_hw),
    .start_store (start_store),
    .start_swrec (start_swrec)
  );

  assign erase_en     = (phase == PH_ERASE);
  assign prog_en      = (phase == PH_PROG);
  assign clear_en     = (phase == PH_CLEAR);
  assign xfer_en      = (phase == PH_XFER);
  assign op_running   = (phase != PH_IDLE);
  assign access_block = op_running || pend || !supply_ok;
  assign busy_n       = !(erase_en || prog_en || (hw_op && (clear_en || xfer_en)));

endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk #(
  parameter int unsigned ERASE_CYC = 5
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic erase_en,
  input logic prog_en,
  input logic clear_en,
  input logic xfer_en,
  input logic access_block,
  input logic busy_n,
  input logic st_store,
  input logic st_swrec,
  input logic st_hw
);

  int unsigned erase_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        erase_run <= 0;
    else if (erase_en) erase_run <= erase_run + 1;
    else               erase_run <= 0;
  end

  assert_one_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_en, prog_en, clear_en, xfer_en}));

  assert_erase_to_prog_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_en) && $past(supply_ok) |-> prog_en);

  assert_erase_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |-> erase_run < ERASE_CYC);

  assert_store_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st_store |=> erase_en);

  assert_clear_to_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clear_en) && $past(supply_ok) |-> xfer_en);

  assert_swrec_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_swrec |=> (clear_en && busy_n));

  assert_phase_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_en || prog_en || clear_en || xfer_en) |-> access_block);

  assert_store_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_en || prog_en) |-> !busy_n);

  assert_hw_recall_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_hw |=> (clear_en && !busy_n));

  assert_drop_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!(erase_en || prog_en || clear_en || xfer_en) && access_block));

endmodule

bind nvs_seq nvs_seq_chk #(.ERASE_CYC(ERASE_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .supply_ok    (supply_ok),
  .erase_en     (erase_en),
  .prog_en      (prog_en),
  .clear_en     (clear_en),
  .xfer_en      (xfer_en),
  .access_block (access_block),
  .busy_n       (busy_n),
  .st_store     (start_store),
  .st_swrec     (start_swrec),
  .st_hw        (take_hw)
);

// File: tb/nvs_seq_test.sv
`timescale 1ns/1ps
module nvs_seq_test;

  localparam int unsigned E_C = 5;
  localparam int unsigned P_C = 7;
  localparam int unsigned C_C = 3;
  localparam int unsigned X_C = 4;

  // Output vector {erase, prog, clear, xfer, busy_n, access_block}
  localparam logic [5:0] V_ERASE = 6'b100001;
  localparam logic [5:0] V_PROG  = 6'b010001;
  localparam logic [5:0] V_HWCLR = 6'b001001;
  localparam logic [5:0] V_HWXFR = 6'b000101;
  localparam logic [5:0] V_SWCLR = 6'b001011;
  localparam logic [5:0] V_SWXFR = 6'b000111;
  localparam logic [5:0] V_IDLE  = 6'b000010;
  localparam logic [5:0] V_LOW   = 6'b000011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic store_req = 1'b0;
  logic recall_req = 1'b0;
  logic erase_en, prog_en, clear_en, xfer_en, access_block, busy_n;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  nvs_seq #(.ERASE_CYC(E_C), .PROG_CYC(P_C), .CLEAR_CYC(C_C), .XFER_CYC(X_C)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .store_req(store_req), .recall_req(recall_req),
    .erase_en(erase_en), .prog_en(prog_en), .clear_en(clear_en), .xfer_en(xfer_en),
    .access_block(access_block), .busy_n(busy_n)
  );

  task automatic check_vec(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {erase_en, prog_en, clear_en, xfer_en, busy_n, access_block};
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // Check n consecutive cycles, one sample per falling edge
  task automatic expect_run(input string req, input int n, input logic [5:0] exp);
    for (int i = 0; i < n; i++) begin
      check_vec(req, exp);
      @(negedge clk);
    end
  endtask

  task automatic pulse(input logic st, input logic rc);
    store_req  = st;
    recall_req = rc;
    @(negedge clk);
    store_req  = 1'b0;
    recall_req = 1'b0;
  endtask

  task automatic t_reset_recall;
    repeat (3) @(negedge clk);
    check_vec("R5", V_LOW);
    rst_n = 1'b1;
    @(negedge clk);
    expect_run("R5", C_C, V_HWCLR);
    expect_run("R4", X_C, V_HWXFR);
    check_vec("R3", V_IDLE);
  endtask

  task automatic t_store;
    pulse(1'b1, 1'b0);
    expect_run("R1", E_C, V_ERASE);
    expect_run("R1", P_C, V_PROG);
    expect_run("R3", 2, V_IDLE);
  endtask

  task automatic t_sw_recall;
    pulse(1'b0, 1'b1);
    expect_run("R2", C_C, V_SWCLR);
    expect_run("R2", X_C, V_SWXFR);
    expect_run("R3", 2, V_IDLE);
  endtask

  task automatic t_ignore_busy;
    pulse(1'b1, 1'b0);
    expect_run("R1", 2, V_ERASE);
    store_req  = 1'b1;
    recall_req = 1'b1;
    check_vec("R7", V_ERASE);
    @(negedge clk);
    store_req  = 1'b0;
    recall_req = 1'b0;
    expect_run("R7", E_C - 3, V_ERASE);
    expect_run("R7", P_C, V_PROG);
    expect_run("R7", 3, V_IDLE);
  endtask

  task automatic t_supply_drop;
    pulse(1'b1, 1'b0);
    expect_run("R1", 3, V_ERASE);
    supply_ok = 1'b0;
    check_vec("R6", {4'b1000, 1'b0, 1'b1});
    @(negedge clk);
    expect_run("R6", 3, V_LOW);
    supply_ok = 1'b1;
    @(negedge clk);
    expect_run("R6", C_C, V_HWCLR);
    expect_run("R6", X_C, V_HWXFR);
    check_vec("R6", V_IDLE);
  endtask

  task automatic t_pend_over_store;
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    pulse(1'b1, 1'b0);
    expect_run("R8", C_C, V_HWCLR);
    expect_run("R8", X_C, V_HWXFR);
    expect_run("R8", 2, V_IDLE);
  endtask

  task automatic t_store_over_recall;
    pulse(1'b1, 1'b1);
    expect_run("R9", E_C, V_ERASE);
    expect_run("R9", P_C, V_PROG);
    expect_run("R9", 2, V_IDLE);
  endtask

  initial begin
    t_reset_recall();
    t_store();
    t_sw_recall();
    t_ignore_busy();
    t_supply_drop();
    t_pend_over_store();
    t_store_over_recall();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule